// File: doc/BRIEF.md
# Two-Bank Interleaved Access Scheduler

This block sits between a pipeline that produces up to two memory accesses per cycle and a cache split into two banks. Each bank covers every other 64-bit word: words whose byte address has bit 3 clear go to bank 0, and words with bit 3 set go to bank 1. A cycle may carry two loads, or one load together with one store. When the two accesses of a cycle fall in different banks, both go out in that cycle, one on each bank port.

When both accesses of a pair need the same bank, the slot 0 access goes out at once. The slot 1 access is parked in a single holding register and goes out on that bank exactly one cycle later. This keeps program order. In the cycle after a deferral, the held access owns its bank. A new access to the other bank can still go out alongside it. If a new access would need the bank the held access is about to use, the block drops `req_ready` for that cycle and stalls the pair upstream. A registered counter totals these stall cycles, so the cost of a badly aligned access stream can be measured. A stream whose accesses all fall in one bank is reduced to one access per cycle.

The holding register is controlled by a three-state machine:

- `HOLD_EMPTY`: nothing is parked.
- `HOLD_BANK0`: an access is parked for bank 0.
- `HOLD_BANK1`: an access is parked for bank 1.

From any state, a same-bank pair accepted in the current cycle moves the machine to the state for that bank (transition *park*). Any other cycle returns it to `HOLD_EMPTY` (transition *drain*), because a parked access always goes out in the very next cycle.

Top module: `bank_pair_sched`

## Requirements
- R1: An access whose address has bit 3 (parameter `BANK_BIT`) equal to 0 is issued only on bank 0, and one with that bit equal to 1 only on bank 1. Two 32-bit accesses in the same 8-byte word therefore go to the same bank.
- R2: When the accepted accesses of a cycle target different banks, both are granted in that same cycle.
- R3: When both slots are accepted and target the same bank, slot 0 is granted in that cycle. Slot 1 is granted on the same bank in the following cycle.
- R4: In the cycle after a deferral, the bank of the held access grants the held access. An accepted new access to the other bank is granted in that same cycle.
- R5: While an access is held, `req_ready` is low in any cycle where a valid slot targets the held bank. Nothing from the request slots is issued in that cycle, and the pair is taken once `req_ready` returns high.
- R6: Every grant carries the address, store flag, write data and request ID of the access it issues, unchanged.
- R7: `stall_cycles` increases by one after every clock edge at which `req_ready` was low while a request was valid.
- R8: After reset, nothing is held, `req_ready` is high, neither bank grant is asserted and `stall_cycles` is zero.
- R9: A stream of pairs whose accesses all target one bank sustains one access per cycle. N pairs take 2N-1 request cycles and add N-1 stall cycles.
- R10: A single valid access in either slot, with the other slot idle, is granted in the cycle it is accepted, provided it does not collide with a held access.
- R11: Two stores are never presented in the same cycle. The block relies on this as an input rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req0_valid | input | 1 | Slot 0 (older) access present |
| req0_addr | input | 32 | Slot 0 byte address |
| req0_store | input | 1 | Slot 0 is a store (1) or a load (0) |
| req0_wdata | input | 64 | Slot 0 store data |
| req0_id | input | 4 | Slot 0 request ID |
| req1_valid | input | 1 | Slot 1 (younger) access present |
| req1_addr | input | 32 | Slot 1 byte address |
| req1_store | input | 1 | Slot 1 is a store (1) or a load (0) |
| req1_wdata | input | 64 | Slot 1 store data |
| req1_id | input | 4 | Slot 1 request ID |
| req_ready | output | 1 | The pair presented this cycle is accepted |
| bank0_grant | output | 1 | Bank 0 issues an access this cycle |
| bank0_addr | output | 32 | Address issued on bank 0 |
| bank0_store | output | 1 | Store flag issued on bank 0 |
| bank0_wdata | output | 64 | Store data issued on bank 0 |
| bank0_id | output | 4 | Request ID issued on bank 0 |
| bank1_grant | output | 1 | Bank 1 issues an access this cycle |
| bank1_addr | output | 32 | Address issued on bank 1 |
| bank1_store | output | 1 | Store flag issued on bank 1 |
| bank1_wdata | output | 64 | Store data issued on bank 1 |
| bank1_id | output | 4 | Request ID issued on bank 1 |
| stall_cycles | output | 16 | Count of conflict stall cycles |

## Verification
Some results appear in the same cycle as the stimulus, with no register in the path: `req_ready` and the grants and tags of accesses that go out without conflict. A deferred access appears after exactly one rising edge. A stall shows up in `stall_cycles` one edge after the stalled cycle, because the counter is registered. The bench drives inputs just after the falling edge and samples every output one time unit before the next rising edge. It checks each cycle against a bench-side model of the held entry and the expected stall total, so that every result is compared in the cycle it is due. The sweep covers every combination of slot occupancy and bank choice over two consecutive pairs. A directed one-bank stream then measures the throughput floor.

// File: rtl/bps_pkg.sv
package bps_pkg;

    localparam int ACC_ADDR_W = 32;
    localparam int ACC_DATA_W = 64;
    localparam int ACC_ID_W   = 4;

    // State of the single holding entry
    typedef enum logic [1:0] {
        HOLD_EMPTY = 2'd0,
        HOLD_BANK0 = 2'd1,
        HOLD_BANK1 = 2'd2
    } hold_state_e;

    // One memory access together with its tag
    typedef struct packed {
        logic [ACC_ADDR_W-1:0] addr;
        logic                  store;
        logic [ACC_DATA_W-1:0] wdata;
        logic [ACC_ID_W-1:0]   id;
    } access_t;

endpackage

// File: rtl/bps_hold_fsm.sv
module bps_hold_fsm
    import bps_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    park_i,
    input  logic    park_bank_i,
    input  access_t park_acc_i,
    output logic    hold_valid_o,
    output logic    hold_bank_o,
    output access_t hold_acc_o
);

    hold_state_e state_q, state_d;
    access_t     entry_q;

    // Next state: park into the conflicting bank, otherwise drain
    always_comb begin
        state_d = HOLD_EMPTY;
        if (park_i) begin
            state_d = park_bank_i ? HOLD_BANK1 : HOLD_BANK0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Entry payload: only loaded on a park
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else if (park_i) begin
            entry_q <= park_acc_i;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        hold_valid_o = 1'b0;
        hold_bank_o  = 1'b0;
        unique case (state_q)
            HOLD_EMPTY: begin
                hold_valid_o = 1'b0;
                hold_bank_o  = 1'b0;
            end
            HOLD_BANK0: begin
                hold_valid_o = 1'b1;
                hold_bank_o  = 1'b0;
            end
            HOLD_BANK1: begin
                hold_valid_o = 1'b1;
                hold_bank_o  = 1'b1;
            end
            default: begin
                hold_valid_o = 1'b0;
                hold_bank_o  = 1'b0;
            end
        endcase
    end

    assign hold_acc_o = entry_q;

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {HOLD_EMPTY, HOLD_BANK0, HOLD_BANK1}); // R3

    AST_HOLD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid_o && !park_i) |=> !hold_valid_o); // R3

endmodule

// File: rtl/bps_steer.sv
module bps_steer
    import bps_pkg::*;
#(
    parameter int BANK_BIT = 3
) (
    input  logic    fire_i,
    input  logic    hold_valid_i,
    input  logic    hold_bank_i,
    input  access_t hold_acc_i,
    input  logic    v0_i,
    input  access_t a0_i,
    input  logic    v1_i,
    input  access_t a1_i,
    output logic [1:0] grant_o,
    output access_t bank_acc_o [2],
    output logic    park_o,
    output logic    park_bank_o,
    output access_t park_acc_o
);

    localparam int NUM_BANKS = 2;

    logic b0, b1;
    assign b0 = a0_i.addr[BANK_BIT];
    assign b1 = a1_i.addr[BANK_BIT];

    // Same-bank pair accepted: slot 1 goes to the holding entry
    assign park_o      = fire_i && v0_i && v1_i && (b0 == b1);
    assign park_bank_o = b1;
    assign park_acc_o  = a1_i;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam logic KB = 1'(k);
        logic    g;
        access_t a;

        // Priority per bank: held entry, then slot 0, then slot 1
        always_comb begin
            g = 1'b0;
            a = '0;
            if (hold_valid_i && hold_bank_i == KB) begin
                g = 1'b1;
                a = hold_acc_i;
            end else if (fire_i && v0_i && b0 == KB) begin
                g = 1'b1;
                a = a0_i;
            end else if (fire_i && v1_i && b1 == KB) begin
                g = 1'b1;
                a = a1_i;
            end
        end

        assign grant_o[k]    = g;
        assign bank_acc_o[k] = a;
    end

endmodule

// File: rtl/bps_stall_counter.sv
module bps_stall_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (stall_i && count_q != CNT_MAX) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    AST_STALL_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1)); // R7

    AST_NO_STALL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i |=> $stable(count_q)); // R7

endmodule

// File: rtl/bank_pair_sched.sv
module bank_pair_sched
    import bps_pkg::*;
#(
    parameter int BANK_BIT = 3,
    parameter int CNT_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req0_valid,
    input  logic [ACC_ADDR_W-1:0] req0_addr,
    input  logic                  req0_store,
    input  logic [ACC_DATA_W-1:0] req0_wdata,
    input  logic [ACC_ID_W-1:0]   req0_id,
    input  logic                  req1_valid,
    input  logic [ACC_ADDR_W-1:0] req1_addr,
    input  logic                  req1_store,
    input  logic [ACC_DATA_W-1:0] req1_wdata,
    input  logic [ACC_ID_W-1:0]   req1_id,
    output logic                  req_ready,
    output logic                  bank0_grant,
    output logic [ACC_ADDR_W-1:0] bank0_addr,
    output logic                  bank0_store,
    output logic [ACC_DATA_W-1:0] bank0_wdata,
    output logic [ACC_ID_W-1:0]   bank0_id,
    output logic                  bank1_grant,
    output logic [ACC_ADDR_W-1:0] bank1_addr,
    output logic                  bank1_store,
    output logic [ACC_DATA_W-1:0] bank1_wdata,
    output logic [ACC_ID_W-1:0]   bank1_id,
    output logic [CNT_W-1:0]      stall_cycles
);

    access_t    acc0, acc1;
    logic       sel0, sel1;
    logic       hold_valid, hold_bank;
    access_t    hold_acc;
    logic       fire, stall;
    logic       park, park_bank;
    access_t    park_acc;
    logic [1:0] grant;
    access_t    bank_acc [2];

    assign acc0 = '{addr: req0_addr, store: req0_store, wdata: req0_wdata, id: req0_id};
    assign acc1 = '{addr: req1_addr, store: req1_store, wdata: req1_wdata, id: req1_id};
    assign sel0 = req0_addr[BANK_BIT];
    assign sel1 = req1_addr[BANK_BIT];

    // Back-pressure only when a new access collides with the held bank
    assign req_ready = !(hold_valid &&
                         ((req0_valid && sel0 == hold_bank) ||
                          (req1_valid && sel1 == hold_bank)));
    assign fire  = req_ready && (req0_valid || req1_valid);
    assign stall = !req_ready;

    bps_hold_fsm u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .park_i       (park),
        .park_bank_i  (park_bank),
        .park_acc_i   (park_acc),
        .hold_valid_o (hold_valid),
        .hold_bank_o  (hold_bank),
        .hold_acc_o   (hold_acc)
    );

    bps_steer #(.BANK_BIT(BANK_BIT)) u_steer (
        .fire_i       (fire),
        .hold_valid_i (hold_valid),
        .hold_bank_i  (hold_bank),
        .hold_acc_i   (hold_acc),
        .v0_i         (req0_valid),
        .a0_i         (acc0),
        .v1_i         (req1_valid),
        .a1_i         (acc1),
        .grant_o      (grant),
        .bank_acc_o   (bank_acc),
        .park_o       (park),
        .park_bank_o  (park_bank),
        .park_acc_o   (park_acc)
    );

    bps_stall_counter #(.CNT_W(CNT_W)) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall_i (stall),
        .count_o (stall_cycles)
    );

    assign bank0_grant = grant[0];
    assign bank0_addr  = bank_acc[0].addr;
    assign bank0_store = bank_acc[0].store;
    assign bank0_wdata = bank_acc[0].wdata;
    assign bank0_id    = bank_acc[0].id;
    assign bank1_grant = grant[1];
    assign bank1_addr  = bank_acc[1].addr;
    assign bank1_store = bank_acc[1].store;
    assign bank1_wdata = bank_acc[1].wdata;
    assign bank1_id    = bank_acc[1].id;

    AST_BANK0_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        bank0_grant |-> !bank0_addr[BANK_BIT]); // R1

    AST_BANK1_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        bank1_grant |-> bank1_addr[BANK_BIT]); // R1

    AST_SPLIT_BOTH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req0_valid && req1_valid && sel0 != sel1) |-> (bank0_grant && bank1_grant)); // R2

    AST_DEFER_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req0_valid && req1_valid && !sel0 && !sel1)
        |=> (bank0_grant && bank0_id == $past(req1_id) && bank0_addr == $past(req1_addr))); // R3

    AST_DEFER_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req0_valid && req1_valid && sel0 && sel1)
        |=> (bank1_grant && bank1_id == $past(req1_id) && bank1_addr == $past(req1_addr))); // R3

    AST_HELD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        hold_valid |-> (grant[hold_bank] && bank_acc[hold_bank] == hold_acc)); // R4

    AST_STALL_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (hold_valid && !park)); // R5

    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_valid |-> req_ready); // R8

    AST_NO_DUAL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (req0_valid && req1_valid) |-> !(req0_store && req1_store)); // R11

endmodule

// File: tb/bank_pair_sched_test.sv
module bank_pair_sched_test;
    import bps_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req0_valid = 1'b0, req1_valid = 1'b0;
    logic [ACC_ADDR_W-1:0] req0_addr = '0, req1_addr = '0;
    logic                  req0_store = 1'b0, req1_store = 1'b0;
    logic [ACC_DATA_W-1:0] req0_wdata = '0, req1_wdata = '0;
    logic [ACC_ID_W-1:0]   req0_id = '0, req1_id = '0;
    logic                  req_ready;
    logic                  bank0_grant, bank1_grant;
    logic [ACC_ADDR_W-1:0] bank0_addr, bank1_addr;
    logic                  bank0_store, bank1_store;
    logic [ACC_DATA_W-1:0] bank0_wdata, bank1_wdata;
    logic [ACC_ID_W-1:0]   bank0_id, bank1_id;
    logic [CNT_W-1:0]      stall_cycles;

    int errors = 0;
    int checks = 0;

    // Bench-side model of the held access and the stall total
    logic    mh_v = 1'b0;
    logic    mh_b = 1'b0;
    access_t mh   = '0;
    int      m_stall = 0;
    int      grants_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_pair_sched #(.BANK_BIT(3), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .req0_valid(req0_valid), .req0_addr(req0_addr), .req0_store(req0_store),
        .req0_wdata(req0_wdata), .req0_id(req0_id),
        .req1_valid(req1_valid), .req1_addr(req1_addr), .req1_store(req1_store),
        .req1_wdata(req1_wdata), .req1_id(req1_id),
        .req_ready(req_ready),
        .bank0_grant(bank0_grant), .bank0_addr(bank0_addr), .bank0_store(bank0_store),
        .bank0_wdata(bank0_wdata), .bank0_id(bank0_id),
        .bank1_grant(bank1_grant), .bank1_addr(bank1_addr), .bank1_store(bank1_store),
        .bank1_wdata(bank1_wdata), .bank1_id(bank1_id),
        .stall_cycles(stall_cycles)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic access_t mk(input int seq, input int slot, input logic bank);
        access_t a;
        a.addr  = ACC_ADDR_W'((seq << 4) | (int'(bank) << 3) | (slot << 2));
        a.store = (slot == 1) && seq[0];          // R11: slot 0 always loads
        a.wdata = ACC_DATA_W'((seq << 8) | slot);
        a.id    = ACC_ID_W'(seq * 2 + slot);
        return a;
    endfunction

    // One request cycle, repeated while the pair is not accepted
    task automatic step(input logic v0, input logic b0, input logic v1, input logic b1,
                        input int seq, output int cycles);
        access_t s0, s1, ea;
        logic    rdy, fire, eg;
        logic    acc_now;
        s0 = mk(seq, 0, b0);
        s1 = mk(seq, 1, b1);
        cycles = 0;
        acc_now = 1'b0;
        while (!acc_now) begin
            @(negedge clk);
            req0_valid = v0; req0_addr = s0.addr; req0_store = s0.store;
            req0_wdata = s0.wdata; req0_id = s0.id;
            req1_valid = v1; req1_addr = s1.addr; req1_store = s1.store;
            req1_wdata = s1.wdata; req1_id = s1.id;
            #(CLK_PERIOD/2 - 1);
            rdy  = !(mh_v && ((v0 && b0 == mh_b) || (v1 && b1 == mh_b)));
            fire = rdy && (v0 || v1);
            chk("R5", "ready", 128'(req_ready), 128'(rdy));
            chk("R7", "stall_cycles", 128'(stall_cycles), 128'(m_stall));
            for (int k = 0; k < 2; k++) begin
                eg = 1'b0; ea = '0;
                if (mh_v && mh_b == 1'(k)) begin eg = 1'b1; ea = mh; end
                else if (fire && v0 && b0 == 1'(k)) begin eg = 1'b1; ea = s0; end
                else if (fire && v1 && b1 == 1'(k)) begin eg = 1'b1; ea = s1; end
                if (k == 0) begin
                    chk("R1 R2 R3 R4 R10", "bank0 grant", 128'(bank0_grant), 128'(eg));
                    if (eg) begin
                        chk("R6", "bank0 addr", 128'(bank0_addr), 128'(ea.addr));
                        chk("R6", "bank0 id", 128'(bank0_id), 128'(ea.id));
                        chk("R6", "bank0 store", 128'(bank0_store), 128'(ea.store));
                        chk("R6", "bank0 wdata", 128'(bank0_wdata), 128'(ea.wdata));
                    end
                end else begin
                    chk("R1 R2 R3 R4 R10", "bank1 grant", 128'(bank1_grant), 128'(eg));
                    if (eg) begin
                        chk("R6", "bank1 addr", 128'(bank1_addr), 128'(ea.addr));
                        chk("R6", "bank1 id", 128'(bank1_id), 128'(ea.id));
                        chk("R6", "bank1 store", 128'(bank1_store), 128'(ea.store));
                        chk("R6", "bank1 wdata", 128'(bank1_wdata), 128'(ea.wdata));
                    end
                end
            end
            grants_seen += int'(bank0_grant) + int'(bank1_grant);
            @(posedge clk);
            if (!rdy && (v0 || v1)) m_stall++;
            mh_v = fire && v0 && v1 && (b0 == b1);
            mh_b = b1;
            if (mh_v) mh = s1;
            acc_now = rdy || !(v0 || v1);
            cycles++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int st0, g0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8", "ready", 128'(req_ready), 128'(1));
        chk("R8", "bank0 grant", 128'(bank0_grant), 128'(0));
        chk("R8", "bank1 grant", 128'(bank1_grant), 128'(0));
        chk("R8", "stall_cycles", 128'(stall_cycles), 128'(0));

        // Sweep: two consecutive request patterns, each over slot occupancy and banks
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                int seq;
                seq = (i * 12 + j) * 2;
                step(i / 4 != 1, 1'(i % 2), i / 4 != 0, 1'((i / 2) % 2), seq, n);
                step(j / 4 != 1, 1'(j % 2), j / 4 != 0, 1'((j / 2) % 2), seq + 1, n);
                step(1'b0, 1'b0, 1'b0, 1'b0, 0, n);
            end
        end

        // R9: one-bank stream of 8 pairs (all addresses with bit 3 set)
        st0 = m_stall;
        g0  = grants_seen;
        begin
            int total;
            total = 0;
            for (int p = 0; p < 8; p++) begin
                step(1'b1, 1'b1, 1'b1, 1'b1, 300 + p, n);
                total += n;
            end
            step(1'b0, 1'b0, 1'b0, 1'b0, 0, n);
            chk("R9", "request cycles for 8 pairs", 128'(total), 128'(15));
            chk("R9", "stall delta", 128'(m_stall - st0), 128'(7));
            chk("R9", "grants over stream", 128'(grants_seen - g0), 128'(16));
        end
        @(negedge clk);
        chk("R7", "final stall_cycles", 128'(stall_cycles), 128'(m_stall));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule